// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor

This combinational block takes two WIDTH-bit two's-complement operands and either adds them or subtracts the second from the first, as chosen by a one-bit mode input. Both operations go through one carry-lookahead adder. In subtract mode each bit of the second operand is XOR-ed with the mode bit, and the mode bit also enters the adder as its carry-in. The adder therefore sees the two's complement of the second operand.

Three flags come out with the sum. The first is the raw carry out of the top bit. The second is a signed overflow flag, formed from the carry into the top bit and the carry out of it. The third is the carry into the top bit itself, brought out as a port so that a neighbouring unit can use it. The carry chain is built from groups of GROUP bits. Each group resolves its carries in two levels from the group carry-in, and the groups pass their carries from one to the next.

Top module: `addsub_top`

## Requirements
- R1: When `sub_mode` is 0, `result` equals (`opnd_a` + `opnd_b`) modulo 2^WIDTH.
- R2: When `sub_mode` is 1, `result` equals (`opnd_a` - `opnd_b`) modulo 2^WIDTH. If `opnd_b` is greater than `opnd_a`, the result is the negative difference in two's-complement form.
- R3: `carry_out` is the carry leaving bit WIDTH-1. With `sub_mode` 0 it is 1 exactly when the unsigned sum reaches 2^WIDTH. With `sub_mode` 1 it is 1 exactly when `opnd_a` >= `opnd_b` as unsigned values.
- R4: `overflow` equals `msb_carry_in` XOR `carry_out`.
- R5: `overflow` is 1 exactly when the signed result is wrong. For addition, this means both operands have the same sign bit and the sign bit of `result` differs from it. For subtraction, this means the operands' sign bits differ and the sign bit of `result` differs from that of `opnd_a`.
- R6: The carry and the overflow flag are independent. At WIDTH 4, -7+7 and 5+(-3) give `carry_out`=1 with `overflow`=0, and 4+4 gives `overflow`=1 with `carry_out`=0 and `result`=4'b1000.
- R7: Subtracting the most negative value from any non-negative `opnd_a` raises `overflow`. At WIDTH 8, 0-(-128) gives `result`=8'h80 and `overflow`=1.
- R8: `msb_carry_in` is the carry into bit WIDTH-1. This is bit WIDTH-1 of the sum of the low WIDTH-1 bits of `opnd_a`, the low WIDTH-1 bits of the (conditionally inverted) `opnd_b`, and `sub_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand, two's complement |
| opnd_b | input | WIDTH | Second operand, two's complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the most significant bit |
| overflow | output | 1 | Signed overflow flag |
| msb_carry_in | output | 1 | Carry into the most significant bit |

## Verification
The bench checks the overflow flag against a rule computed from the operand and result sign bits. A design that takes overflow from the carry-out alone fails on -7+7 and 5+(-3), where it would flag overflow, and on 4+4, where it would miss it. A design that forgets to inject the mode bit as carry-in gives results that are one too small in every subtraction. A design that complements B without flipping the sign rule misses the overflow from 0-(-128). Random operands cross both lookahead group boundaries, so a group carry that is passed on wrongly shows up as a corrupt upper nibble or a wrong `msb_carry_in`.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int DEF_WIDTH = 8;
    localparam int DEF_GROUP = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // per-bit (or per-span) generate / propagate pair
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    function automatic gp_t make_gp(input logic a, input logic b);
        gp_t r;
        r.gen  = a & b;
        r.prop = a ^ b;
        return r;
    endfunction

    // combine a more significant span with the span directly below it
    function automatic gp_t merge_gp(input gp_t upper, input gp_t lower);
        gp_t r;
        r.gen  = upper.gen | (upper.prop & lower.gen);
        r.prop = upper.prop & lower.prop;
        return r;
    endfunction

endpackage

// File: rtl/addsub_bcond.sv
module addsub_bcond
    import addsub_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] b_in,
    input  op_e              op,
    output logic [WIDTH-1:0] b_eff,
    output logic             cin
);
    logic inv;
    assign inv = (op == OP_SUB);
    assign cin = inv;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_eff[i] = b_in[i] ^ inv;
    end
endmodule

// File: rtl/addsub_gp_stage.sv
module addsub_gp_stage
    import addsub_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output gp_t  [WIDTH-1:0] gp
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gp[i] = make_gp(a[i], b[i]);
    end
endmodule

// File: rtl/addsub_lookahead.sv
module addsub_lookahead
    import addsub_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int GROUP = DEF_GROUP
) (
    input  gp_t  [WIDTH-1:0] gp,
    input  logic             cin,
    output logic [WIDTH:0]   carry
);
    localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

    logic [NGRP-1:0] gcin;

    assign carry[0] = cin;
    assign gcin[0]  = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GROUP;
        localparam int HI = (LO + GROUP > WIDTH) ? WIDTH - 1 : LO + GROUP - 1;
        localparam int SZ = HI - LO + 1;

        gp_t [SZ-1:0] span;

        // span[k] covers bits LO..LO+k, each formed directly from the bit pairs
        always_comb begin
            for (int k = 0; k < SZ; k++) begin
                gp_t acc;
                acc = gp[LO + k];
                for (int j = k - 1; j >= 0; j--) begin
                    acc = merge_gp(acc, gp[LO + j]);
                end
                span[k] = acc;
            end
        end

        for (genvar k = 0; k < SZ; k++) begin : g_c
            assign carry[LO + k + 1] = span[k].gen | (span[k].prop & gcin[g]);
        end

        if (g < NGRP - 1) begin : g_next
            assign gcin[g + 1] = carry[HI + 1];
        end
    end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags (
    input  logic c_into_msb,
    input  logic c_out_msb,
    output logic cout,
    output logic ovf,
    output logic msb_cin
);
    assign cout    = c_out_msb;
    assign msb_cin = c_into_msb;
    assign ovf     = c_into_msb ^ c_out_msb;
endmodule

// File: rtl/addsub_top.sv
module addsub_top
    import addsub_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int GROUP = DEF_GROUP
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             msb_carry_in
);
    op_e              op;
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    gp_t  [WIDTH-1:0] gp;
    logic [WIDTH:0]   carry;

    assign op = op_e'(sub_mode);

    addsub_bcond #(.WIDTH(WIDTH)) bcond_i (
        .b_in  (opnd_b),
        .op    (op),
        .b_eff (b_eff),
        .cin   (cin)
    );

    addsub_gp_stage #(.WIDTH(WIDTH)) gp_i (
        .a  (opnd_a),
        .b  (b_eff),
        .gp (gp)
    );

    addsub_lookahead #(.WIDTH(WIDTH), .GROUP(GROUP)) cla_i (
        .gp    (gp),
        .cin   (cin),
        .carry (carry)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign result[i] = gp[i].prop ^ carry[i];
    end

    addsub_flags flags_i (
        .c_into_msb (carry[WIDTH-1]),
        .c_out_msb  (carry[WIDTH]),
        .cout       (carry_out),
        .ovf        (overflow),
        .msb_cin    (msb_carry_in)
    );
endmodule

// File: rtl/addsub_chk.sv
module addsub_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             sub_mode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow,
    input logic             msb_carry_in
);
    logic [WIDTH:0]   ref_sum;
    logic [WIDTH-1:0] b_ref;
    logic             known;

    always_comb begin
        b_ref   = sub_mode ? ~opnd_b : opnd_b;
        ref_sum = {1'b0, opnd_a} + {1'b0, b_ref} + {{WIDTH{1'b0}}, sub_mode};
        known   = !$isunknown({opnd_a, opnd_b, sub_mode, result,
                               carry_out, overflow, msb_carry_in});
        if (known) begin
            // R1 R2 R3
            sum_value_chk: assert ({carry_out, result} == ref_sum);
            // R4
            ovf_pair_chk: assert (overflow == (msb_carry_in ^ carry_out));
            // R5
            sign_rule_chk: assert (overflow ==
                ((opnd_a[WIDTH-1] == b_ref[WIDTH-1]) &&
                 (result[WIDTH-1] != opnd_a[WIDTH-1])));
            // R7
            min_sub_chk: assert (!(sub_mode && !opnd_a[WIDTH-1] &&
                opnd_b == {1'b1, {(WIDTH-1){1'b0}}}) || overflow);
        end
    end
endmodule

bind addsub_top addsub_chk #(.WIDTH(WIDTH)) chk_i (
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .sub_mode     (sub_mode),
    .result       (result),
    .carry_out    (carry_out),
    .overflow     (overflow),
    .msb_carry_in (msb_carry_in)
);

// File: tb/addsub_top_tb_top.sv
module addsub_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [7:0] a_drv = '0, b_drv = '0;
    logic       m_drv = 1'b0;
    logic [7:0] res;
    logic       co, ov, mc;

    logic [3:0] a4 = '0, b4 = '0;
    logic       m4 = 1'b0;
    logic [3:0] res4;
    logic       co4, ov4, mc4;

    int n_chk  = 0;
    int n_fail = 0;

    addsub_top #(.WIDTH(8), .GROUP(4)) dut_i (
        .opnd_a(a_drv), .opnd_b(b_drv), .sub_mode(m_drv),
        .result(res), .carry_out(co), .overflow(ov), .msb_carry_in(mc)
    );

    addsub_top #(.WIDTH(4), .GROUP(4)) dut4_i (
        .opnd_a(a4), .opnd_b(b4), .sub_mode(m4),
        .result(res4), .carry_out(co4), .overflow(ov4), .msb_carry_in(mc4)
    );

    typedef struct {
        logic [7:0] a, b;
        logic       m;
        logic [7:0] res;
        logic       co, ov, mc;
        string      note;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: compute expectation from signed arithmetic, drive, push
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic m,
                         input string note);
        exp_t e;
        int sa, sb, full;
        logic [8:0] low;
        sa   = int'($signed(a));
        sb   = int'($signed(b));
        full = m ? sa - sb : sa + sb;
        e.a = a; e.b = b; e.m = m; e.note = note;
        e.res = full[7:0];
        e.co  = m ? (a >= b) : ((int'(a) + int'(b)) > 255);
        e.ov  = m ? ((a[7] != b[7]) && (e.res[7] != a[7]))
                  : ((a[7] == b[7]) && (e.res[7] != a[7]));
        low   = {2'b0, a[6:0]} + {2'b0, (m ? ~b[6:0] : b[6:0])} + {8'b0, m};
        e.mc  = low[7];
        @(posedge clk);
        a_drv = a; b_drv = b; m_drv = m;
        sb_q.push_back(e);
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(res == e.res, {e.m ? "R2 result " : "R1 result ", e.note},
                  int'(res), int'(e.res));
            check(co == e.co, {"R3 carry_out ", e.note}, int'(co), int'(e.co));
            check(ov == e.ov, {"R5 overflow ", e.note}, int'(ov), int'(e.ov));
            check(ov == (mc ^ co), {"R4 ovf vs carry pair ", e.note},
                  int'(ov), int'(mc ^ co));
            check(mc == e.mc, {"R8 msb_carry_in ", e.note}, int'(mc), int'(e.mc));
        end
    end

    task automatic chk4(input logic [3:0] a, input logic [3:0] b, input logic m,
                        input logic [3:0] eres, input logic eco, input logic eov,
                        input string tag);
        @(posedge clk);
        a4 = a; b4 = b; m4 = m;
        @(negedge clk);
        check(res4 == eres, {tag, " result"}, int'(res4), int'(eres));
        check(co4 == eco, {tag, " carry_out"}, int'(co4), int'(eco));
        check(ov4 == eov, {tag, " overflow"}, int'(ov4), int'(eov));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero operands give all-zero outputs (R1)
        check(res == 8'h00 && co == 1'b0 && ov == 1'b0 && mc == 1'b0,
              "R1 reset-state outputs", int'({res, co, ov, mc}), 0);
        rst = 1'b0;

        // R1 / R2 plain cases, including B > A in subtraction
        apply(8'd20, 8'd22, 1'b0, "20+22");
        apply(8'd5, 8'd9, 1'b1, "R2 5-9 negative");
        apply(8'd9, 8'd5, 1'b1, "9-5");
        apply(8'hFF, 8'h01, 1'b0, "-1+1 wrap");
        apply(8'h00, 8'h00, 1'b1, "0-0 carry set");
        apply(8'h0F, 8'h01, 1'b0, "group carry 15+1");
        // R6 carry without overflow, overflow without carry
        apply(8'h81, 8'h7F, 1'b0, "R6 -127+127");
        apply(8'h05, 8'hFD, 1'b0, "R6 5+(-3)");
        apply(8'h40, 8'h40, 1'b0, "R6 64+64");
        apply(8'h80, 8'h80, 1'b0, "neg+neg overflow");
        // R7 most negative subtrahend
        apply(8'h00, 8'h80, 1'b1, "R7 0-(-128)");
        apply(8'h7F, 8'h80, 1'b1, "R7 127-(-128)");
        apply(8'h80, 8'h80, 1'b1, "-128-(-128)");
        apply(8'h80, 8'h01, 1'b1, "-128-1 overflow");
        apply(8'h7F, 8'hFF, 1'b1, "127-(-1) overflow");

        for (int i = 0; i < 400; i++) begin
            apply(8'($urandom), 8'($urandom), 1'($urandom), "random");
        end
        @(posedge clk);
        @(posedge clk);

        // R6 literal 4-bit cases
        chk4(4'b1001, 4'b0111, 1'b0, 4'b0000, 1'b1, 1'b0, "R6 4b -7+7");
        chk4(4'b0101, 4'b1101, 1'b0, 4'b0010, 1'b1, 1'b0, "R6 4b 5+(-3)");
        chk4(4'b0100, 4'b0100, 1'b0, 4'b1000, 1'b0, 1'b1, "R6 4b 4+4");
        chk4(4'b0000, 4'b1000, 1'b1, 4'b1000, 1'b0, 1'b1, "R7 4b 0-(-8)");
        chk4(4'b0011, 4'b0101, 1'b1, 4'b1110, 1'b0, 1'b0, "R2 4b 3-5");

        finish_run();
    end

endmodule